// File: doc/BRIEF.md
# VGA Extended Register Port Decoder

This block sits on the host I/O port bus of a graphics controller and answers byte reads and writes in the VGA register window. It keeps the miscellaneous output byte, the sequencer index, an extension-enable byte and a bank of vendor extension registers. It also keeps a CRTC index register so that the monochrome/colour aliasing of the 0x3Bx and 0x3Dx ports can be observed. A global setup port at 0x46E8 switches decoding of the whole 0x3C0–0x3DF window on and off.

Addresses in 0x3B0–0x3BF and 0x3D0–0x3DF are XORed with 0x60 while the colour-select bit (bit 0 of the miscellaneous byte) is clear, so software written for either CRTC base reaches the same register. Any read the block does not answer returns 0xFF with a not-claimed flag, which lets a neighbouring decoder (timing, DAC, attribute) serve the access. Read data is registered: it appears on the clock edge that samples the read strobe and holds until the next read.

Top module: `vga_xreg_decoder`

## Requirements
- R1: After reset the miscellaneous byte is 0x01, window decoding is on, the extension-enable byte, sequencer index and CRTC index are 0x00, clockSel is 0, rdData is 0x00 and notClaimed is 0.
- R2: A write to 0x3C2 loads the miscellaneous byte; a read of 0x3CC returns it.
- R3: A write to 0x3C2 sets clockSel to bits 3:2 of the written byte.
- R4: While bit 0 of the miscellaneous byte is 0, an address in 0x3B0–0x3BF or 0x3D0–0x3DF is XORed with 0x60 before decode; the CRTC index register lives at decoded address 0x3D4 (read and write), so in colour mode 0x3D4 reaches it and 0x3B4 is not claimed, and in mono mode the reverse.
- R5: Port 0x3C4 reads and writes the sequencer index; port 0x3C5 with index 0x06 reads and writes the extension-enable byte.
- R6: With the extension-enable byte nonzero, port 0x3C5 with an index of 0x80 or above reads and writes one byte of the extension bank selected by that index.
- R7: With the extension-enable byte zero, a read of 0x3C5 at an index of 0x80 or above returns 0x00 and is claimed, and a write there leaves the bank unchanged.
- R8: A write to 0x46E8 sets window decoding to bit 3 of the byte, whether or not decoding is on; with decoding off, every read in the (remapped) window returns 0xFF not claimed and every write there is ignored.
- R9: Reads of addresses not listed above (including 0x3C5 at a standard index other than 0x06, 0x3D5, 0x3C2 and 0x46E8) return 0xFF with notClaimed set.
- R10: rdData and notClaimed change only on a clock edge where rdEn is high, taking the result of that read, and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| portAddr | input | 16 | Host port address |
| wrData | input | 8 | Host write byte |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access |
| rdData | output | 8 | Registered read byte |
| notClaimed | output | 1 | High when the last read was not answered |
| clockSel | output | 2 | Clock-select low bits taken from the miscellaneous byte |

## Verification
The bench goes after the address alias in both colour and mono mode: a decoder that remaps in the wrong mode, or remaps the 0x3Cx ports too, would answer 0x3B4 when it should leave it to another block. It writes an extension register while extensions are off and then reads it back after enabling them, which catches a bank that accepts gated writes, and it reads the bank while gated to catch a decoder leaking stored data or returning 0xFF. It turns window decoding off and confirms that a miscellaneous write is dropped and that the setup port itself still works, and it checks that clockSel follows the written bits and that read data holds across idle cycles.

// File: rtl/vxd_pkg.sv
package vxd_pkg;
  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] PORT_MISC_WR = 16'h03C2;
  localparam logic [ADDR_W-1:0] PORT_MISC_RD = 16'h03CC;
  localparam logic [ADDR_W-1:0] PORT_SEQ_IDX = 16'h03C4;
  localparam logic [ADDR_W-1:0] PORT_SEQ_DAT = 16'h03C5;
  localparam logic [ADDR_W-1:0] PORT_CRTC_IDX = 16'h03D4;
  localparam logic [ADDR_W-1:0] PORT_SETUP = 16'h46E8;
  localparam logic [ADDR_W-1:0] ALIAS_MONO = 16'h03B0;
  localparam logic [ADDR_W-1:0] ALIAS_COLOR = 16'h03D0;
  localparam logic [ADDR_W-1:0] ALIAS_FLIP = 16'h0060;
  localparam logic [ADDR_W-6:0] WINDOW_TAG = 11'h01E;

  typedef enum logic [2:0] {
    RD_NONE, RD_MISC, RD_SEQIDX, RD_EXTEN, RD_BANK, RD_CRTCIDX
  } rdSel_e;

  typedef struct packed {
    logic   wrMisc;
    logic   wrSeqIdx;
    logic   wrExtEn;
    logic   wrBank;
    logic   wrCrtcIdx;
    logic   wrSetup;
    rdSel_e rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/vxd_ctrl.sv
module vxd_ctrl
  import vxd_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int EXT_BASE   = 128,
  parameter int EXT_EN_IDX = 6
) (
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              wrEn,
  input  logic              colorMode,
  input  logic              decodeEn,
  input  logic              extOn,
  input  logic [IDX_W-1:0]  seqIdx,
  output ctrlStrobes_t      strobes
);
  logic [ADDR_W-1:0] blockBase;
  logic [ADDR_W-1:0] mappedAddr;
  logic              aliasHit;
  logic              inWindow;
  logic              isExtIdx;
  logic              isEnIdx;

  always_comb begin
    blockBase  = portAddr & 16'hFFF0;
    aliasHit   = (blockBase == ALIAS_MONO) || (blockBase == ALIAS_COLOR);
    mappedAddr = (aliasHit && !colorMode) ? (portAddr ^ ALIAS_FLIP) : portAddr;
    inWindow   = decodeEn && (mappedAddr[ADDR_W-1:5] == WINDOW_TAG);
    isExtIdx   = seqIdx >= IDX_W'(EXT_BASE);
    isEnIdx    = seqIdx == IDX_W'(EXT_EN_IDX);
  end

  always_comb begin
    strobes         = '0;
    strobes.rdSel   = RD_NONE;
    strobes.wrSetup = wrEn && (portAddr == PORT_SETUP);
    if (inWindow) begin
      unique case (mappedAddr)
        PORT_MISC_WR: strobes.wrMisc = wrEn;
        PORT_MISC_RD: strobes.rdSel = RD_MISC;
        PORT_SEQ_IDX: begin
          strobes.wrSeqIdx = wrEn;
          strobes.rdSel    = RD_SEQIDX;
        end
        PORT_SEQ_DAT: begin
          if (isEnIdx) begin
            strobes.wrExtEn = wrEn;
            strobes.rdSel   = RD_EXTEN;
          end else if (isExtIdx) begin
            strobes.wrBank = wrEn && extOn;
            strobes.rdSel  = RD_BANK;
          end
        end
        PORT_CRTC_IDX: begin
          strobes.wrCrtcIdx = wrEn;
          strobes.rdSel     = RD_CRTCIDX;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vxd_datapath.sv
module vxd_datapath
  import vxd_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int IDX_W        = 8,
  parameter int EXT_BASE     = 128,
  parameter int SETUP_EN_BIT = 3,
  parameter logic [DATA_W-1:0] MISC_RESET = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] misc,
  output logic [1:0]        clockSel,
  output logic              decodeEn,
  output logic [DATA_W-1:0] extEnable,
  output logic [IDX_W-1:0]  seqIdx,
  output logic [IDX_W-1:0]  crtcIdx,
  output logic              extOn,
  output logic [DATA_W-1:0] rdData,
  output logic              notClaimed
);
  localparam int EXT_DEPTH = (1 << IDX_W) - EXT_BASE;
  localparam int EXT_IDX_W = (EXT_DEPTH > 1) ? $clog2(EXT_DEPTH) : 1;

  logic [DATA_W-1:0]    bank [EXT_DEPTH];
  logic [IDX_W-1:0]     bankOffs;
  logic [EXT_IDX_W-1:0] bankSel;
  logic [DATA_W-1:0]    rdNext;

  assign extOn    = |extEnable;
  assign bankOffs = seqIdx - IDX_W'(EXT_BASE);
  assign bankSel  = bankOffs[EXT_IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misc      <= MISC_RESET;
      clockSel  <= '0;
      decodeEn  <= 1'b1;
      extEnable <= '0;
      seqIdx    <= '0;
      crtcIdx   <= '0;
    end else begin
      if (strobes.wrMisc) begin
        misc     <= wrData;
        clockSel <= wrData[3:2];
      end
      if (strobes.wrSetup)   decodeEn  <= wrData[SETUP_EN_BIT];
      if (strobes.wrExtEn)   extEnable <= wrData;
      if (strobes.wrSeqIdx)  seqIdx    <= wrData;
      if (strobes.wrCrtcIdx) crtcIdx   <= wrData;
    end
  end

  for (genvar g = 0; g < EXT_DEPTH; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank[g] <= '0;
      else if (strobes.wrBank && (bankSel == EXT_IDX_W'(g)))
        bank[g] <= wrData;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_MISC:    rdNext = misc;
      RD_SEQIDX:  rdNext = seqIdx;
      RD_EXTEN:   rdNext = extEnable;
      RD_BANK:    rdNext = extOn ? bank[bankSel] : '0;
      RD_CRTCIDX: rdNext = crtcIdx;
      default:    rdNext = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData     <= '0;
      notClaimed <= 1'b0;
    end else if (rdEn) begin
      rdData     <= rdNext;
      notClaimed <= (strobes.rdSel == RD_NONE);
    end
  end
endmodule

// File: rtl/vga_xreg_decoder.sv
module vga_xreg_decoder
  import vxd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 8,
  parameter int EXT_BASE = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       portAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              notClaimed,
  output logic [1:0]        clockSel
);
  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] misc;
  logic              decodeEn;
  logic [DATA_W-1:0] extEnable;
  logic [IDX_W-1:0]  seqIdx;
  logic [IDX_W-1:0]  crtcIdx;
  logic              extOn;

  vxd_ctrl #(.IDX_W(IDX_W), .EXT_BASE(EXT_BASE), .EXT_EN_IDX(6)) u_ctrl (
    .portAddr (portAddr),
    .wrEn     (wrEn),
    .colorMode(misc[0]),
    .decodeEn (decodeEn),
    .extOn    (extOn),
    .seqIdx   (seqIdx),
    .strobes  (strobes)
  );

  vxd_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W), .EXT_BASE(EXT_BASE),
                 .SETUP_EN_BIT(3), .MISC_RESET(8'h01)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rdEn      (rdEn),
    .wrData    (wrData),
    .strobes   (strobes),
    .misc      (misc),
    .clockSel  (clockSel),
    .decodeEn  (decodeEn),
    .extEnable (extEnable),
    .seqIdx    (seqIdx),
    .crtcIdx   (crtcIdx),
    .extOn     (extOn),
    .rdData    (rdData),
    .notClaimed(notClaimed)
  );
endmodule

// File: rtl/vxd_checker.sv
module vxd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] portAddr,
  input logic [7:0]  wrData,
  input logic        wrEn,
  input logic        rdEn,
  input logic [7:0]  rdData,
  input logic        notClaimed,
  input logic [1:0]  clockSel,
  input logic [7:0]  misc,
  input logic        decodeEn,
  input logic [7:0]  extEnable,
  input logic [7:0]  seqIdx,
  input logic [7:0]  crtcIdx
);
  assert_misc_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && decodeEn && portAddr == 16'h03C2) |=> (misc == $past(wrData)));

  assert_misc_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !wrEn && decodeEn && portAddr == 16'h03CC) |=> (rdData == $past(misc) && !notClaimed));

  assert_clock_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && decodeEn && portAddr == 16'h03C2) |=> (clockSel == $past(wrData[3:2])));

  assert_mono_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !wrEn && decodeEn && !misc[0] && portAddr == 16'h03B4) |=> (rdData == $past(crtcIdx) && !notClaimed));

  assert_color_unclaimed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && misc[0] && portAddr == 16'h03B4) |=> (notClaimed && rdData == 8'hFF));

  assert_ext_enable_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && decodeEn && portAddr == 16'h03C5 && seqIdx == 8'h06) |=> (extEnable == $past(wrData)));

  assert_gated_bank_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && decodeEn && extEnable == 8'h00 && portAddr == 16'h03C5 && seqIdx >= 8'h80) |=> (rdData == 8'h00 && !notClaimed));

  assert_setup_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && portAddr == 16'h46E8) |=> (decodeEn == $past(wrData[3])));

  assert_window_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !decodeEn) |=> (notClaimed && rdData == 8'hFF));

  assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |=> ($stable(rdData) && $stable(notClaimed)));
endmodule

bind vga_xreg_decoder vxd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .portAddr  (portAddr),
  .wrData    (wrData),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .rdData    (rdData),
  .notClaimed(notClaimed),
  .clockSel  (clockSel),
  .misc      (misc),
  .decodeEn  (decodeEn),
  .extEnable (extEnable),
  .seqIdx    (seqIdx),
  .crtcIdx   (crtcIdx)
);

// File: tb/vga_xreg_decoder_test.sv
module vga_xreg_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] portAddr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic        notClaimed;
  logic [1:0]  clockSel;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [7:0] mMisc = 8'h01;
  logic [1:0] mClk = 2'd0;
  logic       mDec = 1'b1;
  logic [7:0] mExt = 8'h00;
  logic [7:0] mIdx = 8'h00;
  logic [7:0] mCrtc = 8'h00;
  logic [7:0] mBank [128];

  always #5 clk = ~clk;

  vga_xreg_decoder uut (
    .clk(clk), .rst_n(rst_n), .portAddr(portAddr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData), .notClaimed(notClaimed),
    .clockSel(clockSel)
  );

  function automatic logic [15:0] remapAddr(input logic [15:0] a);
    logic [15:0] hi;
    hi = a & 16'hFFF0;
    if ((hi == 16'h03B0 || hi == 16'h03D0) && !mMisc[0]) return a ^ 16'h0060;
    return a;
  endfunction

  // returns {notClaimed, data}
  function automatic logic [8:0] modelRead(input logic [15:0] a);
    logic [15:0] m;
    m = remapAddr(a);
    if (a == 16'h46E8 || !mDec || m[15:5] != 11'h01E) return {1'b1, 8'hFF};
    case (m)
      16'h03CC: return {1'b0, mMisc};
      16'h03C4: return {1'b0, mIdx};
      16'h03D4: return {1'b0, mCrtc};
      16'h03C5: begin
        if (mIdx == 8'h06) return {1'b0, mExt};
        if (mIdx >= 8'h80) return {1'b0, (mExt != 0) ? mBank[mIdx[6:0]] : 8'h00};
        return {1'b1, 8'hFF};
      end
      default: return {1'b1, 8'hFF};
    endcase
  endfunction

  task automatic modelWrite(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] m;
    m = remapAddr(a);
    if (a == 16'h46E8) begin
      mDec = d[3];
      return;
    end
    if (!mDec || m[15:5] != 11'h01E) return;
    case (m)
      16'h03C2: begin mMisc = d; mClk = d[3:2]; end
      16'h03C4: mIdx = d;
      16'h03D4: mCrtc = d;
      16'h03C5: begin
        if (mIdx == 8'h06) mExt = d;
        else if (mIdx >= 8'h80 && mExt != 0) mBank[mIdx[6:0]] = d;
      end
      default: ;
    endcase
  endtask

  task automatic busOp(input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    portAddr = a; wrData = d; wrEn = w; rdEn = !w;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    busOp(1'b1, a, d);
    modelWrite(a, d);
  endtask

  task automatic compare(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual nc=%0b data=%02h expected nc=%0b data=%02h",
               tag, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic checkRead(input string tag, input logic [15:0] a);
    logic [8:0] exp;
    exp = modelRead(a);
    busOp(1'b0, a, 8'h00);
    compare(tag, {notClaimed, rdData}, exp);
  endtask

  task automatic checkClk(input string tag);
    compare(tag, {7'd0, clockSel}, {7'd0, mClk});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mBank[i] = 8'h00;
    void'($urandom(32'd20240522));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    compare("R1 rdData/notClaimed after reset", {notClaimed, rdData}, 9'h000);
    checkClk("R1 clockSel after reset");
    checkRead("R1 R2 misc reset value", 16'h03CC);
    checkRead("R1 seq index reset", 16'h03C4);

    // R2 R3 misc and clock select
    doWrite(16'h03C2, 8'h0D);
    checkClk("R3 clockSel=3");
    checkRead("R2 misc readback", 16'h03CC);
    repeat (3) @(negedge clk);
    compare("R10 read data held while idle", {notClaimed, rdData}, {1'b0, 8'h0D});

    // R4 alias
    doWrite(16'h03D4, 8'h11);
    checkRead("R4 colour crtc index", 16'h03D4);
    checkRead("R4 colour 3B4 unclaimed", 16'h03B4);
    doWrite(16'h03C2, 8'h04);
    checkClk("R3 clockSel=1");
    checkRead("R4 mono 3B4 reaches crtc", 16'h03B4);
    checkRead("R4 mono 3D4 unclaimed", 16'h03D4);
    doWrite(16'h03B4, 8'h22);
    checkRead("R4 mono write through 3B4", 16'h03B4);
    checkRead("R4 misc not aliased", 16'h03CC);
    doWrite(16'h03C2, 8'h01);
    checkRead("R4 colour sees mono write", 16'h03D4);

    // R5 index and enable
    doWrite(16'h03C4, 8'h06);
    checkRead("R5 seq index", 16'h03C4);
    checkRead("R5 enable reg zero", 16'h03C5);

    // R7 gated bank
    doWrite(16'h03C4, 8'h85);
    doWrite(16'h03C5, 8'hAB);
    checkRead("R7 gated read returns 00", 16'h03C5);
    doWrite(16'h03C4, 8'h06);
    doWrite(16'h03C5, 8'h01);
    checkRead("R5 enable reg readback", 16'h03C5);
    doWrite(16'h03C4, 8'h85);
    checkRead("R7 gated write ignored", 16'h03C5);

    // R6 bank access
    doWrite(16'h03C5, 8'h5A);
    checkRead("R6 bank 0x85", 16'h03C5);
    doWrite(16'h03C4, 8'hFF);
    doWrite(16'h03C5, 8'hA5);
    checkRead("R6 bank 0xFF", 16'h03C5);
    doWrite(16'h03C4, 8'h80);
    checkRead("R6 bank 0x80 untouched", 16'h03C5);
    doWrite(16'h03C4, 8'h06);
    doWrite(16'h03C5, 8'h00);
    doWrite(16'h03C4, 8'hFF);
    checkRead("R7 gated read hides stored data", 16'h03C5);

    // R9 unclaimed
    doWrite(16'h03C4, 8'h10);
    checkRead("R9 standard seq index unclaimed", 16'h03C5);
    checkRead("R9 3D5 unclaimed", 16'h03D5);
    checkRead("R9 46E8 read unclaimed", 16'h46E8);
    checkRead("R9 3C2 read unclaimed", 16'h03C2);
    checkRead("R9 outside window", 16'h0300);

    // R8 window off
    doWrite(16'h46E8, 8'h00);
    checkRead("R8 window off misc read", 16'h03CC);
    doWrite(16'h03C2, 8'h00);
    doWrite(16'h46E8, 8'h08);
    checkRead("R8 write ignored while off", 16'h03CC);
    checkClk("R8 clockSel unchanged while off");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int pick;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0: a = 16'h03C2; 1: a = 16'h03CC; 2: a = 16'h03C4; 3: a = 16'h03C5;
        4: a = 16'h03D4; 5: a = 16'h03B4; 6: a = 16'h03D5; 7: a = 16'h46E8;
        8: a = 16'h03C5; default: a = 16'h03C0;
      endcase
      d = 8'($urandom);
      if (a == 16'h46E8) d[3] = ($urandom_range(0, 7) != 0);
      if (a == 16'h03C4) begin
        case ($urandom_range(0, 3))
          0: d = 8'h06; 1: d = 8'h10; default: d = {1'b1, d[6:0]};
        endcase
      end
      if (a == 16'h03C5 && mIdx == 8'h06) d = ($urandom_range(0, 3) == 0) ? 8'h00 : d;
      if ($urandom_range(0, 1) == 0) doWrite(a, d);
      else checkRead("R2-R9 random mix", a);
      if (n % 50 == 0) checkClk("R3 random clockSel");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule